// File: doc/BRIEF.md
# Segmented IR Sample Ring Buffer

This block holds received infrared samples in a logical ring that is spread over three physical memory segments. The first segment is fixed, eight entries long and sits at a parameter base address. The other two each take a base address and a length that the host programs byte by byte through a small indexed configuration port. A producer port pushes sample bytes at the hardware write position. The host pulls them one at a time with a read request. Each request is answered one cycle later with the physical byte address that the current ring index maps to and the sample stored there. An address of zero means the ring held no data.

The programmed layout is checked continuously. If the total length or either extra base is out of range, or the read pointer lies past the end of the ring, the block drops to a fallback mode. In that mode the ring is just the eight-entry main segment, split into two halves, and a status input picks which half the write pointer names. Raising the enable input lines the read pointer up with the write pointer, so stale samples are never returned.

Top module: `seg_ring_buf`

## Requirements
- R1: After reset rsp_valid, overflow and cfg_ok are 0, rd_ptr is 0, and with legacy_half at 0 wr_ptr is 4. Reset clears every descriptor byte, which gives a total length of 8.
- R2: A read that hits ring index i with i in 0..7 returns rsp_addr = MAIN_BASE + i.
- R3: Ring index 8 + j with j below the first extra length returns first base + j. Index 8 + len1 + j with j below the second extra length returns second base + j.
- R4: A read request while enabled gives rsp_valid for one cycle, one cycle later. On a hit it returns the byte stored at rd_ptr and moves rd_ptr up by one. rd_ptr goes back to 0 when the increment reaches the ring length. The ring length is 8 + len1 + len2 in normal mode and 8 in fallback mode.
- R5: empty is 1 while rd_ptr equals wr_ptr. A request while empty answers with rsp_addr 0 and rsp_data 0 and leaves rd_ptr unchanged.
- R6: cfg_ok is 1 only when all of these hold: the total length is within 16..64, both extra bases are within 0xEC00..0xFBFC, and rd_ptr is no greater than the total.
- R7: While cfg_ok is 0 the ring length is 8. wr_ptr is 0 when legacy_half is 1 and 4 when it is 0. Producer writes never raise overflow in this mode.
- R8: The configuration bytes are addressed as follows. Index 0 is the first base low byte, 1 its high byte and 2 its length. Indices 3, 4 and 5 hold the same three fields for the second segment. Writes to indices 6 and 7 change nothing.
- R9: In the cycle where enable rises, rd_ptr takes the current wr_ptr and overflow clears. A request made in that cycle gets no response.
- R10: A producer write while enabled stores its byte at the write position, which then advances and wraps to 0 at the ring length. In normal mode, a write whose advanced position would equal rd_ptr is dropped and sets overflow. overflow then stays set until the next enable rise.
- R11: While enable is 0, read requests get no response and producer writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Buffer enable; a rising edge resynchronises the read pointer |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_idx | input | 3 | Configuration byte index |
| cfg_data | input | 8 | Configuration byte value |
| prod_wr | input | 1 | Producer sample write strobe |
| prod_data | input | 8 | Producer sample byte |
| legacy_half | input | 1 | Fallback-mode half select for the write pointer |
| rd_req | input | 1 | Host read request |
| rsp_valid | output | 1 | Read response strobe |
| rsp_addr | output | 16 | Physical address of the sample read, 0 when none |
| rsp_data | output | 8 | Sample byte read, 0 when none |
| rd_ptr | output | 7 | Host read pointer |
| wr_ptr | output | 7 | Effective write pointer |
| empty | output | 1 | Read pointer equals write pointer |
| overflow | output | 1 | Sticky producer overflow flag |
| cfg_ok | output | 1 | Configuration is valid (normal mode) |

## Verification
A corrupted descriptor byte or a misplaced segment boundary shows at the next read that crosses into the affected segment, as a wrong rsp_addr. For a bad base or length, cfg_ok shows it in the same cycle the byte is written. A read or write pointer that steps or wraps wrongly shows on rd_ptr and wr_ptr within one cycle. It then shows again a few reads later, when the data comes back out of order or an empty response arrives early. A lost overflow flag or a write that overran the reader is visible on overflow at once. It also shows as missing samples when the ring is drained.

// File: rtl/segring_pkg.sv
package segring_pkg;
  localparam int ADDR_W = 16;
  localparam int TOT_W  = 10;
  localparam int NSEG   = 2;
  localparam int DESC_B = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [7:0]        len;
  } seg_t;

  // next ring position, wrapping when the increment reaches the length
  function automatic logic [TOT_W-1:0] ring_next(input logic [TOT_W-1:0] p,
                                                 input logic [TOT_W-1:0] len);
    logic [TOT_W-1:0] q;
    q = p + 1'b1;
    return (q >= len) ? '0 : q;
  endfunction

  // logical ring index to physical byte address; 0 past the last segment
  function automatic logic [ADDR_W-1:0] index_to_addr(input logic [TOT_W-1:0] idx,
                                                      input logic [ADDR_W-1:0] main_base,
                                                      input logic [TOT_W-1:0] main_len,
                                                      input seg_t a, input seg_t b);
    logic [TOT_W-1:0] off;
    if (idx < main_len) return main_base + ADDR_W'(idx);
    off = idx - main_len;
    if (off < TOT_W'(a.len)) return a.base + ADDR_W'(off);
    off = off - TOT_W'(a.len);
    if (off < TOT_W'(b.len)) return b.base + ADDR_W'(off);
    return '0;
  endfunction
endpackage

// File: rtl/seg_cfg.sv
module seg_cfg
  import segring_pkg::*;
#(
  parameter int          MAIN_LEN  = 8,
  parameter int          DEPTH_MAX = 64,
  parameter int          LEN_MIN   = 16,
  parameter logic [15:0] BASE_MIN  = 16'hEC00,
  parameter logic [15:0] BASE_MAX  = 16'hFBFC,
  parameter int          PTR_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_idx,
  input  logic [7:0]       cfg_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output seg_t             seg_a,
  output seg_t             seg_b,
  output logic [TOT_W-1:0] total,
  output logic             cfg_ok
);
  seg_t segs [NSEG];
  logic [NSEG-1:0] base_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSEG; s++) segs[s] <= '0;
    end else if (cfg_wr) begin
      for (int s = 0; s < NSEG; s++) begin
        if (cfg_idx == 3'(DESC_B*s))     segs[s].base[7:0]  <= cfg_data;
        if (cfg_idx == 3'(DESC_B*s + 1)) segs[s].base[15:8] <= cfg_data;
        if (cfg_idx == 3'(DESC_B*s + 2)) segs[s].len        <= cfg_data;
      end
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_base
    assign base_ok[s] = (segs[s].base >= BASE_MIN) && (segs[s].base <= BASE_MAX);
  end

  assign seg_a  = segs[0];
  assign seg_b  = segs[1];
  assign total  = TOT_W'(MAIN_LEN) + TOT_W'(segs[0].len) + TOT_W'(segs[1].len);
  assign cfg_ok = (total >= TOT_W'(LEN_MIN)) && (total <= TOT_W'(DEPTH_MAX)) &&
                  (&base_ok) && (TOT_W'(rd_ptr) <= total);
endmodule

// File: rtl/seg_store.sv
module seg_store #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import segring_pkg::*;
#(
  parameter int          MAIN_LEN  = 8,
  parameter logic [15:0] MAIN_BASE = 16'hF540,
  parameter int          PTR_W     = 7,
  parameter int          IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             prod_wr,
  input  logic             rd_req,
  input  logic             legacy_half,
  input  logic             cfg_ok,
  input  logic [TOT_W-1:0] total,
  input  seg_t             seg_a,
  input  seg_t             seg_b,
  input  logic [7:0]       store_rdata,
  output logic             store_we,
  output logic [IDX_W-1:0] store_widx,
  output logic [IDX_W-1:0] store_ridx,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             empty,
  output logic             overflow,
  output logic             rsp_valid,
  output logic [15:0]      rsp_addr,
  output logic [7:0]       rsp_data
);
  localparam int HALF = MAIN_LEN / 2;

  logic [PTR_W-1:0] w_q, rd_q, w_next;
  logic [TOT_W-1:0] ring_len;
  logic en_q, legacy, en_rise, pop_ok, pop_hit, push_ok, push_block, push_go;

  assign legacy     = !cfg_ok;
  assign ring_len   = legacy ? TOT_W'(MAIN_LEN) : total;
  assign wr_ptr     = legacy ? (legacy_half ? '0 : PTR_W'(HALF)) : w_q;
  assign rd_ptr     = rd_q;
  assign empty      = (rd_q == wr_ptr);
  assign en_rise    = en && !en_q;
  assign pop_ok     = rd_req && en && en_q;
  assign pop_hit    = pop_ok && !empty;
  assign w_next     = PTR_W'(ring_next(TOT_W'(w_q), ring_len));
  assign push_ok    = prod_wr && en;
  assign push_block = push_ok && !legacy && (w_next == rd_q);
  assign push_go    = push_ok && !push_block;

  assign store_we   = push_go;
  assign store_widx = IDX_W'(w_q);
  assign store_ridx = IDX_W'(rd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      w_q       <= '0;
      rd_q      <= '0;
      overflow  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      en_q      <= en;
      rsp_valid <= pop_ok;
      rsp_addr  <= pop_hit ? index_to_addr(TOT_W'(rd_q), MAIN_BASE, TOT_W'(MAIN_LEN),
                                           seg_a, seg_b) : '0;
      rsp_data  <= pop_hit ? store_rdata : '0;
      if (push_go) w_q <= w_next;
      if (en_rise)         overflow <= 1'b0;
      else if (push_block) overflow <= 1'b1;
      if (en_rise)      rd_q <= wr_ptr;
      else if (pop_hit) rd_q <= PTR_W'(ring_next(TOT_W'(rd_q), ring_len));
    end
  end

  p_empty_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && empty |=> rsp_valid && (rsp_addr == '0) && (rsp_data == '0));

  p_rd_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_hit |=> (rd_ptr == '0) || (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

  p_enable_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (rd_ptr == $past(wr_ptr)) && !overflow);

  p_no_overflow_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !en_rise |=> overflow);

  p_idle_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rsp_valid);

  p_no_overflow_legacy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    legacy && !overflow |=> !overflow || $past(en_rise));
endmodule

// File: rtl/seg_ring_buf.sv
module seg_ring_buf
  import segring_pkg::*;
#(
  parameter logic [15:0] MAIN_BASE = 16'hF540,
  parameter int          MAIN_LEN  = 8,
  parameter int          DEPTH_MAX = 64,
  parameter int          LEN_MIN   = 16,
  parameter logic [15:0] BASE_MIN  = 16'hEC00,
  parameter logic [15:0] BASE_MAX  = 16'hFBFC,
  localparam int         PTR_W     = $clog2(DEPTH_MAX + 1),
  localparam int         IDX_W     = $clog2(DEPTH_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_idx,
  input  logic [7:0]       cfg_data,
  input  logic             prod_wr,
  input  logic [7:0]       prod_data,
  input  logic             legacy_half,
  input  logic             rd_req,
  output logic             rsp_valid,
  output logic [15:0]      rsp_addr,
  output logic [7:0]       rsp_data,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             empty,
  output logic             overflow,
  output logic             cfg_ok
);
  seg_t             seg_a, seg_b;
  logic [TOT_W-1:0] total;
  logic             store_we;
  logic [IDX_W-1:0] store_widx, store_ridx;
  logic [7:0]       store_rdata;

  seg_cfg #(
    .MAIN_LEN(MAIN_LEN), .DEPTH_MAX(DEPTH_MAX), .LEN_MIN(LEN_MIN),
    .BASE_MIN(BASE_MIN), .BASE_MAX(BASE_MAX), .PTR_W(PTR_W)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .rd_ptr(rd_ptr), .seg_a(seg_a), .seg_b(seg_b),
    .total(total), .cfg_ok(cfg_ok)
  );

  seg_store #(.DEPTH(DEPTH_MAX)) i_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .widx(store_widx),
    .wdata(prod_data), .ridx(store_ridx), .rdata(store_rdata)
  );

  ring_ctrl #(
    .MAIN_LEN(MAIN_LEN), .MAIN_BASE(MAIN_BASE), .PTR_W(PTR_W), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .en(enable), .prod_wr(prod_wr), .rd_req(rd_req),
    .legacy_half(legacy_half), .cfg_ok(cfg_ok), .total(total),
    .seg_a(seg_a), .seg_b(seg_b), .store_rdata(store_rdata),
    .store_we(store_we), .store_widx(store_widx), .store_ridx(store_ridx),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .empty(empty), .overflow(overflow),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );
endmodule

// File: tb/test_seg_ring_buf.sv
module test_seg_ring_buf;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MBASE = 16'hF540;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, cfg_wr = 0, prod_wr = 0, legacy_half = 0, rd_req = 0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0, prod_data = '0;
  logic rsp_valid, empty, overflow, cfg_ok;
  logic [15:0] rsp_addr;
  logic [7:0] rsp_data;
  logic [6:0] rd_ptr, wr_ptr;

  seg_ring_buf #(.MAIN_BASE(MBASE)) i_seg_ring_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .prod_wr(prod_wr), .prod_data(prod_data),
    .legacy_half(legacy_half), .rd_req(rd_req), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .empty(empty), .overflow(overflow), .cfg_ok(cfg_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_w = 0, m_rd = 0, m_l1 = 0, m_l2 = 0, m_b1 = 0, m_b2 = 0;
  bit m_ovf = 0, m_en = 0;
  logic [7:0] m_mem [64];
  logic [15:0] last_addr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit base_in(input int b);
    return b >= 32'hEC00 && b <= 32'hFBFC;
  endfunction
  function automatic int m_total();
    return 8 + m_l1 + m_l2;
  endfunction
  function automatic bit m_valid();
    int t = m_total();
    return (t >= 16) && (t <= 64) && base_in(m_b1) && base_in(m_b2) && (m_rd <= t);
  endfunction
  function automatic int m_len();
    return m_valid() ? m_total() : 8;
  endfunction
  function automatic int m_wptr();
    if (m_valid()) return m_w;
    return legacy_half ? 0 : 4;
  endfunction
  // physical address from cumulative segment bounds
  function automatic logic [15:0] m_addr(input int idx);
    int e1 = 8 + m_l1, e2 = 8 + m_l1 + m_l2;
    if (idx < 8)  return MBASE + 16'(idx);
    if (idx < e1) return 16'(m_b1 + idx - 8);
    if (idx < e2) return 16'(m_b2 + idx - e1);
    return 16'h0;
  endfunction

  task automatic state_chk();
    chk("R4 rd_ptr", 32'(rd_ptr), m_rd);
    chk(m_valid() ? "R10 wr_ptr" : "R7 wr_ptr", 32'(wr_ptr), m_wptr());
    chk("R10 overflow", 32'(overflow), 32'(m_ovf));
    chk("R6 cfg_ok", 32'(cfg_ok), 32'(m_valid()));
    chk("R5 empty", 32'(empty), 32'(m_rd == m_wptr()));
  endtask

  task automatic cfg_byte(input int idx, input logic [7:0] v);
    cfg_idx = 3'(idx); cfg_data = v; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    case (idx)
      0: m_b1 = (m_b1 & 32'hFF00) | v;
      1: m_b1 = (m_b1 & 32'h00FF) | (int'(v) << 8);
      2: m_l1 = v;
      3: m_b2 = (m_b2 & 32'hFF00) | v;
      4: m_b2 = (m_b2 & 32'h00FF) | (int'(v) << 8);
      5: m_l2 = v;
      default: ;
    endcase
  endtask

  task automatic cfg_all(input int b1, input int l1, input int b2, input int l2);
    cfg_byte(0, 8'(b1)); cfg_byte(1, 8'(b1 >> 8)); cfg_byte(2, 8'(l1));
    cfg_byte(3, 8'(b2)); cfg_byte(4, 8'(b2 >> 8)); cfg_byte(5, 8'(l2));
  endtask

  task automatic go_enable();
    int e = m_wptr();
    enable = 1; @(negedge clk);
    m_rd = e; m_ovf = 0; m_en = 1;
    chk("R9 rd_ptr", 32'(rd_ptr), e);
    chk("R9 overflow", 32'(overflow), 0);
  endtask

  task automatic go_disable();
    enable = 0; @(negedge clk); m_en = 0;
  endtask

  task automatic push(input logic [7:0] d);
    int len = m_len(), nxt;
    bit v = m_valid();
    nxt = (m_w + 1 >= len) ? 0 : m_w + 1;
    prod_wr = 1; prod_data = d; @(negedge clk); prod_wr = 0;
    if (m_en) begin
      if (v && nxt == m_rd) m_ovf = 1;
      else begin m_mem[m_w] = d; m_w = nxt; end
    end
  endtask

  task automatic pop();
    int len = m_len(), idx = m_rd;
    bit hit = m_en && (m_rd != m_wptr());
    logic [15:0] ea = hit ? m_addr(idx) : 16'h0;
    logic [7:0]  ed = hit ? m_mem[idx] : 8'h0;
    bit er = m_en;
    rd_req = 1; @(negedge clk); rd_req = 0;
    last_addr = rsp_addr;
    chk(er ? "R4 rsp_valid" : "R11 rsp_valid", 32'(rsp_valid), 32'(er));
    if (er) begin
      chk(!hit ? "R5 addr" : (idx < 8 ? "R2 addr" : "R3 addr"), 32'(rsp_addr), 32'(ea));
      chk(hit ? "R4 data" : "R5 data", 32'(rsp_data), 32'(ed));
    end
    if (hit) m_rd = (m_rd + 1 >= len) ? 0 : m_rd + 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) m_mem[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 cfg_ok", 32'(cfg_ok), 0);
    chk("R1 rd_ptr", 32'(rd_ptr), 0);
    chk("R1 wr_ptr", 32'(wr_ptr), 4);
    // R7 fallback halves
    legacy_half = 1; #1;
    chk("R7 half1", 32'(wr_ptr), 0);
    legacy_half = 0; #1;
    chk("R7 half0", 32'(wr_ptr), 4);
    @(negedge clk);
    go_enable();
    for (int i = 0; i < 8; i++) push(8'(8'hA0 + i));
    legacy_half = 1; #1;
    state_chk();
    for (int i = 0; i < 5; i++) pop();
    chk("R7 wrap at 8", 32'(rd_ptr), 0);
    state_chk();
    legacy_half = 0;
    go_disable();
    // R6 boundaries
    cfg_all(32'hEC00, 4, 32'hFBFC, 4);  chk("R6 total 16", 32'(cfg_ok), 1);
    cfg_byte(5, 8'd3);                  chk("R6 total 15", 32'(cfg_ok), 0);
    cfg_all(32'hEC00, 28, 32'hFBFC, 28); chk("R6 total 64", 32'(cfg_ok), 1);
    cfg_byte(5, 8'd29);                 chk("R6 total 65", 32'(cfg_ok), 0);
    cfg_all(32'hEBFF, 10, 32'hF000, 10); chk("R6 base low", 32'(cfg_ok), 0);
    cfg_all(32'hFBFD, 10, 32'hF000, 10); chk("R6 base high", 32'(cfg_ok), 0);
    // R8 layout, R3 mapping
    cfg_all(32'hED12, 10, 32'hF3A0, 6);
    chk("R6 cfg_ok", 32'(cfg_ok), 1);
    cfg_byte(6, 8'hFF); cfg_byte(7, 8'h00);
    chk("R8 idx6/7 ignored", 32'(cfg_ok), 1);
    go_enable();
    for (int i = 0; i < 12; i++) push(8'($urandom));
    for (int i = 0; i < 9; i++) pop();
    chk("R8 first extra base", 32'(last_addr), 32'hED12);
    for (int i = 0; i < 3; i++) pop();
    state_chk();
    // R10 overflow
    for (int i = 0; i < 24; i++) push(8'($urandom));
    chk("R10 overflow set", 32'(overflow), 1);
    chk("R10 wr_ptr", 32'(wr_ptr), 11);
    for (int i = 0; i < 24; i++) pop();
    chk("R10 sticky", 32'(overflow), 1);
    state_chk();
    // R11 disabled
    go_disable();
    push(8'h5A);
    chk("R11 push ignored", 32'(wr_ptr), 11);
    pop();
    state_chk();
    go_enable();
    state_chk();
    // randomized layouts
    for (int it = 0; it < 30; it++) begin
      int b1, b2, k;
      go_disable();
      b1 = ($urandom % 8 == 0) ? 32'hEB00 + ($urandom % 256) : 32'hEC00 + ($urandom % 32'hFFD);
      b2 = ($urandom % 8 == 0) ? 32'hFC00 + ($urandom % 256) : 32'hEC00 + ($urandom % 32'hFFD);
      cfg_all(b1, $urandom % 33, b2, $urandom % 33);
      state_chk();
      go_enable();
      state_chk();
      k = $urandom % (m_len() + 3);
      for (int i = 0; i < k; i++) push(8'($urandom));
      state_chk();
      for (int i = 0; i <= k; i++) pop();
      state_chk();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule